// File: doc/BRIEF.md
# Emergency Output High-Impedance Controller

This block releases groups of timer output pins to high impedance when an external fault is seen. Four active-low fault inputs are synchronized. A falling edge on any of them sets a sticky flag. A level compare fault input and two software request bits feed the same shutdown logic. The flags stay set until software clears them by writing ones to a clear mask.

The shutdown paths are split into two domains. Three of the fault pins, the compare fault and one software request trip the high-current complementary output pairs. The fourth fault pin, gated by its own enable, and a second software request trip the single-channel outputs. Each pair and each single pin has its own enable bit. A pin-function qualifier per pin passes the request to the pad only while that pin is used as timer or general I/O. An interrupt request is raised while any flag is set and its interrupt enable is set.

Top module: `pin_fault_hiz`

## Requirements
- R1: After reset, all flags and both software request bits are 0, and `hc_hiz`, `ch0_hiz` and `irq` are 0.
- R2: Each falling edge on a `fault_n` bit sets its flag, and the flag shows on `flags` three clock edges after the input changes. Flag bit 0 is fault input 0, bit 1 is input 1, bit 2 is input 2 and bit 3 is input 3. A rising edge does not set a flag.
- R3: A flag stays set until a cycle with `clr_we` high and the matching `clr_mask` bit at 1. The flag then reads 0 from the next cycle. Flags whose mask bit is 0 are unchanged.
- R4: If a clear and a new set hit the same flag in the same cycle, the flag stays set.
- R5: Pair p drives `hc_hiz` bits 2p and 2p+1. Such a bit is 1 only when all of these hold: `hc_pair_en[p]` is 1, the pin's `hc_func_ok` bit is 1, and at least one of these is true: flag 0, 1 or 2 is set; flag 4 is set with `cmp_en` high; the high-current software request is set.
- R6: `ch0_hiz[i]` is 1 only when `ch0_en[i]` and `ch0_func_ok[i]` are both 1 and either flag 3 is set with `f8_en` high or the single-channel software request is set.
- R7: Flags 0 to 2 never affect `ch0_hiz`, and flag 3 never affects `hc_hiz`.
- R8: A pin whose function-ok bit is 0 never shows high impedance, whatever its flags and enables.
- R9: While `cmp_fault` is high at a clock edge, flag 4 sets on that edge and stays set until cleared as in R3.
- R10: `irq` is 1 exactly when some bit of `flags & irq_en` is 1.
- R11: A cycle with `sw_we` high loads `sw_hc_req` and `sw_ch0_req` into the request registers, which act on the outputs from the next cycle. Writing 0 removes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_n | input | 4 | Active-low fault inputs, asynchronous |
| cmp_fault | input | 1 | Output-level compare fault, sets flag 4 |
| cmp_en | input | 1 | Lets flag 4 trip the high-current pairs |
| f8_en | input | 1 | Lets flag 3 trip the single-channel pins |
| irq_en | input | 5 | Interrupt enable per flag |
| sw_we | input | 1 | Write strobe for the software requests |
| sw_hc_req | input | 1 | Software request data, high-current domain |
| sw_ch0_req | input | 1 | Software request data, single-channel domain |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 5 | Write-one-to-clear mask for the flags |
| hc_pair_en | input | 3 | Enable per high-current pair |
| ch0_en | input | 4 | Enable per single-channel pin |
| hc_func_ok | input | 6 | High-current pin used as timer or general I/O |
| ch0_func_ok | input | 4 | Single-channel pin used as timer or general I/O |
| hc_hiz | output | 6 | High-impedance request, high-current pins |
| ch0_hiz | output | 4 | High-impedance request, single-channel pins |
| flags | output | 5 | Sticky fault flags |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to set up is the race between a clear write and a new edge on the same flag. The clear strobe has to arrive on exactly the clock edge where the synchronized falling edge is latched, which is the third edge after the pin drops. The bench sets the flag once, releases the pin, drops it again, and asserts the clear on that counted edge. The domain isolation is also hard to reach. Each stimulus vector starts from reset, trips one set of faults, and then compares both output groups against a model of the requirements.

// File: rtl/hiz_pkg.sv
package hiz_pkg;
  localparam int NUM_FAULT_IN = 4;
  localparam int NUM_FLAGS    = NUM_FAULT_IN + 1;
  localparam int IDX_A        = 0;
  localparam int IDX_B        = 1;
  localparam int IDX_C        = 2;
  localparam int IDX_SINGLE   = 3;
  localparam int IDX_CMP      = 4;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/fault_edge_sync.sv
module fault_edge_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_n,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] synced;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '1;
      else     chain_q <= {chain_q[STAGES-2:0], in_n[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= synced;
  end

  assign fall_o = prev_q & ~synced;

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0));
endmodule

// File: rtl/fault_flag_bank.sv
module fault_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] clr_hit;

  assign clr_hit = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= set_i | (flag_q & ~clr_hit);
  end

  assign flag_o = flag_q;

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));
  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_we_i) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we_i && ((clr_mask_i & set_i) == '0)) |=> ((flag_q & $past(clr_mask_i)) == '0));
  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we_i && ((clr_mask_i & set_i) != '0)) |=> ((flag_q & $past(clr_mask_i & set_i)) != '0));
endmodule

// File: rtl/hiz_gate.sv
module hiz_gate #(
  parameter int NUM_PAIRS = 3,
  parameter int NUM_CH0   = 4,
  localparam int HC_PINS  = 2 * NUM_PAIRS
) (
  input  logic               hc_trip,
  input  logic               ch0_trip,
  input  logic [NUM_PAIRS-1:0] pair_en,
  input  logic [NUM_CH0-1:0] ch0_en,
  input  logic [HC_PINS-1:0] hc_func_ok,
  input  logic [NUM_CH0-1:0] ch0_func_ok,
  output logic [HC_PINS-1:0] hc_hiz,
  output logic [NUM_CH0-1:0] ch0_hiz
);
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic pair_trip;
    assign pair_trip         = hc_trip & pair_en[p];
    assign hc_hiz[2*p]       = pair_trip & hc_func_ok[2*p];
    assign hc_hiz[2*p+1]     = pair_trip & hc_func_ok[2*p+1];
  end

  for (genvar c = 0; c < NUM_CH0; c++) begin : g_ch0
    assign ch0_hiz[c] = ch0_trip & ch0_en[c] & ch0_func_ok[c];
  end
endmodule

// File: rtl/pin_fault_hiz.sv
module pin_fault_hiz
  import hiz_pkg::*;
#(
  parameter int NUM_PAIRS   = 3,
  parameter int NUM_CH0     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int HC_PINS    = 2 * NUM_PAIRS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_FAULT_IN-1:0] fault_n,
  input  logic                    cmp_fault,
  input  logic                    cmp_en,
  input  logic                    f8_en,
  input  logic [NUM_FLAGS-1:0]    irq_en,
  input  logic                    sw_we,
  input  logic                    sw_hc_req,
  input  logic                    sw_ch0_req,
  input  logic                    clr_we,
  input  logic [NUM_FLAGS-1:0]    clr_mask,
  input  logic [NUM_PAIRS-1:0]    hc_pair_en,
  input  logic [NUM_CH0-1:0]      ch0_en,
  input  logic [HC_PINS-1:0]      hc_func_ok,
  input  logic [NUM_CH0-1:0]      ch0_func_ok,
  output logic [HC_PINS-1:0]      hc_hiz,
  output logic [NUM_CH0-1:0]      ch0_hiz,
  output logic [NUM_FLAGS-1:0]    flags,
  output logic                    irq
);
  logic [NUM_FAULT_IN-1:0] fall;
  flag_vec_t               set_vec;
  flag_vec_t               flag_q;
  logic                    sw_hc_q, sw_ch0_q;
  logic                    hc_trip, ch0_trip;

  fault_edge_sync #(.WIDTH(NUM_FAULT_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .in_n(fault_n), .fall_o(fall)
  );

  assign set_vec = {cmp_fault, fall};

  fault_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_we_i(clr_we),
    .clr_mask_i(clr_mask), .flag_o(flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_hc_q  <= 1'b0;
      sw_ch0_q <= 1'b0;
    end else if (sw_we) begin
      sw_hc_q  <= sw_hc_req;
      sw_ch0_q <= sw_ch0_req;
    end
  end

  assign hc_trip  = flag_q[IDX_A] | flag_q[IDX_B] | flag_q[IDX_C]
                  | (flag_q[IDX_CMP] & cmp_en) | sw_hc_q;
  assign ch0_trip = (flag_q[IDX_SINGLE] & f8_en) | sw_ch0_q;

  hiz_gate #(.NUM_PAIRS(NUM_PAIRS), .NUM_CH0(NUM_CH0)) u_gate (
    .hc_trip(hc_trip), .ch0_trip(ch0_trip), .pair_en(hc_pair_en),
    .ch0_en(ch0_en), .hc_func_ok(hc_func_ok), .ch0_func_ok(ch0_func_ok),
    .hc_hiz(hc_hiz), .ch0_hiz(ch0_hiz)
  );

  assign flags = flag_q;
  assign irq   = |(flag_q & irq_en);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (flags == '0 && hc_hiz == '0 && ch0_hiz == '0 && !irq));
  // R7
  hc_isolation_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q[IDX_C:IDX_A] == '0 && !flag_q[IDX_CMP] && !sw_hc_q) |-> (hc_hiz == '0));
  // R7
  ch0_isolation_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_q[IDX_SINGLE] && !sw_ch0_q) |-> (ch0_hiz == '0));
  // R8
  func_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((hc_hiz & ~hc_func_ok) == '0) && ((ch0_hiz & ~ch0_func_ok) == '0));
endmodule

// File: tb/pin_fault_hiz_tb.sv
module pin_fault_hiz_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] fault_n = 4'hf;
  logic cmp_fault = 0, cmp_en = 0, f8_en = 0;
  logic [4:0] irq_en = 0;
  logic sw_we = 0, sw_hc_req = 0, sw_ch0_req = 0;
  logic clr_we = 0;
  logic [4:0] clr_mask = 0;
  logic [2:0] hc_pair_en = 0;
  logic [3:0] ch0_en = 0;
  logic [5:0] hc_func_ok = 0;
  logic [3:0] ch0_func_ok = 0;
  logic [5:0] hc_hiz;
  logic [3:0] ch0_hiz;
  logic [4:0] flags;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pin_fault_hiz u_dut (
    .clk(clk), .rst(rst), .fault_n(fault_n), .cmp_fault(cmp_fault),
    .cmp_en(cmp_en), .f8_en(f8_en), .irq_en(irq_en), .sw_we(sw_we),
    .sw_hc_req(sw_hc_req), .sw_ch0_req(sw_ch0_req), .clr_we(clr_we),
    .clr_mask(clr_mask), .hc_pair_en(hc_pair_en), .ch0_en(ch0_en),
    .hc_func_ok(hc_func_ok), .ch0_func_ok(ch0_func_ok), .hc_hiz(hc_hiz),
    .ch0_hiz(ch0_hiz), .flags(flags), .irq(irq)
  );

  // fields: faults[35:32] cmp[31] cmp_en[30] f8_en[29] swhc[28] swch0[27]
  //         pair_en[26:24] ch0_en[23:20] hc_func[19:14] ch0_func[13:10]
  localparam int NV = 9;
  localparam logic [35:0] VEC [NV] = '{
    {4'b0001, 5'b00000, 3'b111, 4'b1111, 6'h3f, 4'hf, 10'd0}, // R7 F0 only
    {4'b1000, 5'b00100, 3'b111, 4'b1111, 6'h3f, 4'hf, 10'd0}, // R6 R7
    {4'b1000, 5'b00000, 3'b111, 4'b1111, 6'h3f, 4'hf, 10'd0}, // R6 gated off
    {4'b0000, 5'b11000, 3'b101, 4'b1111, 6'h3f, 4'hf, 10'd0}, // R9 R5
    {4'b0000, 5'b10000, 3'b111, 4'b1111, 6'h3f, 4'hf, 10'd0}, // R5 cmp_en off
    {4'b0000, 5'b00010, 3'b111, 4'b1111, 6'h15, 4'hf, 10'd0}, // R11 R8
    {4'b0000, 5'b00001, 3'b111, 4'b1010, 6'h3f, 4'hf, 10'd0}, // R11 R6
    {4'b0100, 5'b00000, 3'b111, 4'b1111, 6'h00, 4'hf, 10'd0}, // R8
    {4'b1010, 5'b00100, 3'b111, 4'b1111, 6'h3f, 4'h6, 10'd0}  // R5 R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; fault_n = 4'hf; cmp_fault = 0; sw_we = 0; clr_we = 0;
    cycles(2);
    rst = 0;
  endtask

  function automatic logic [5:0] model_hc(input logic [4:0] fl, input logic en_c,
      input logic sw, input logic [2:0] pe, input logic [5:0] fo);
    logic trip = (|fl[2:0]) | (fl[4] & en_c) | sw;
    logic [5:0] r;
    for (int p = 0; p < 3; p++) begin
      r[2*p]   = trip & pe[p] & fo[2*p];
      r[2*p+1] = trip & pe[p] & fo[2*p+1];
    end
    return r;
  endfunction

  function automatic logic [3:0] model_ch0(input logic [4:0] fl, input logic en8,
      input logic sw, input logic [3:0] ce, input logic [3:0] fo);
    logic trip = (fl[3] & en8) | sw;
    return {4{trip}} & ce & fo;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [4:0] exp_fl;
    do_reset();
    // R1 reset state
    hc_pair_en = '1; ch0_en = '1; hc_func_ok = '1; ch0_func_ok = '1;
    f8_en = 1; cmp_en = 1; irq_en = '1;
    cycles(1);
    chk("R1 flags", flags, 0);
    chk("R1 hc_hiz", hc_hiz, 0);
    chk("R1 ch0_hiz", ch0_hiz, 0);
    chk("R1 irq", irq, 0);

    for (int v = 0; v < NV; v++) begin
      logic [35:0] e = VEC[v];
      do_reset();
      cmp_en = e[30]; f8_en = e[29];
      hc_pair_en = e[26:24]; ch0_en = e[23:20];
      hc_func_ok = e[19:14]; ch0_func_ok = e[13:10];
      sw_hc_req = e[28]; sw_ch0_req = e[27]; sw_we = 1;
      fault_n = ~e[35:32]; cmp_fault = e[31];
      cycles(1);
      sw_we = 0; cmp_fault = 0;
      cycles(4);
      exp_fl = {e[31], e[35:32]};
      chk("R2 R9 flags", flags, exp_fl);
      chk("R5 R7 R8 hc_hiz", hc_hiz, model_hc(exp_fl, e[30], e[28], e[26:24], e[19:14]));
      chk("R6 R7 R8 ch0_hiz", ch0_hiz, model_ch0(exp_fl, e[29], e[27], e[23:20], e[13:10]));
      fault_n = 4'hf;
    end

    // R2 timing and rising edge
    do_reset();
    hc_pair_en = '1; hc_func_ok = '1; irq_en = 5'b00010;
    fault_n = 4'b1101;
    cycles(2);
    chk("R2 not before third edge", flags, 0);
    cycles(1);
    chk("R2 third edge", flags, 5'b00010);
    chk("R10 irq on", irq, 1);
    chk("R5 hc on", hc_hiz, 6'h3f);
    clr_we = 1; clr_mask = 5'b00010;
    cycles(1);
    clr_we = 0; clr_mask = 0;
    chk("R3 cleared", flags, 0);
    chk("R10 irq off", irq, 0);
    fault_n = 4'hf;
    cycles(5);
    chk("R2 rising edge ignored", flags, 0);

    // R3 selective clear, R10 enable mask
    fault_n = 4'b1100;
    cycles(4);
    fault_n = 4'hf;
    irq_en = 5'b00100;
    cycles(1);
    chk("R10 unenabled flags", irq, 0);
    clr_we = 1; clr_mask = 5'b00001;
    cycles(1);
    clr_we = 0; clr_mask = 0;
    chk("R3 partial clear", flags, 5'b00010);
    clr_we = 0; clr_mask = 5'b00010;
    cycles(1);
    chk("R3 mask without strobe", flags, 5'b00010);

    // R4 set wins over clear (flag1 already set, new edge)
    clr_mask = 0;
    fault_n = 4'b1101;
    cycles(2);
    clr_we = 1; clr_mask = 5'b00010;
    cycles(1);
    clr_we = 0; clr_mask = 0;
    chk("R4 set wins", flags, 5'b00010);
    fault_n = 4'hf;

    // R9 compare flag sticky, R11 software request removal
    do_reset();
    cmp_fault = 1;
    cycles(1);
    cmp_fault = 0;
    cycles(3);
    chk("R9 sticky", flags, 5'b10000);
    cmp_en = 0; hc_pair_en = '1; hc_func_ok = '1; ch0_en = '1; ch0_func_ok = '1;
    sw_we = 1; sw_hc_req = 1; sw_ch0_req = 1;
    cycles(1);
    sw_we = 0;
    chk("R11 sw hc on", hc_hiz, 6'h3f);
    chk("R11 sw ch0 on", ch0_hiz, 4'hf);
    sw_we = 1; sw_hc_req = 0; sw_ch0_req = 0;
    cycles(1);
    sw_we = 0;
    chk("R11 sw hc off", hc_hiz, 0);
    chk("R11 sw ch0 off", ch0_hiz, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule